// File: doc/BRIEF.md
# Nonvolatile Store Sequencer

This block decides when data-register contents are committed to a modelled nonvolatile array for a bank of digitally controlled potentiometers. A serial framer, outside this block, reports each fully received instruction as a one-cycle command pulse. Three instructions store data: a direct register write, a copy of one wiper value into a register, and a copy of every wiper value into the same register slot of each potentiometer. When one of these arrives, the block captures its payload and arms. The store starts only when chip select is released.

Once started, a write-in-progress flag is held for a fixed, parameterised number of clock cycles that stands for the high-voltage programming time. The stored value becomes visible at the end of that time. A write-protect input sampled at the release of chip select can cancel the store. A status byte carries the progress flag in its least significant bit. A standby indication stays low while a store is running, even when the device is deselected. Storage commands that arrive while a store runs are dropped.

Top module: `nv_store_seq`

## Requirements
- R1: After reset, `wip` is 0, `status_byte` is all zeros, and every stored register reads 0 on the read port.
- R2: Command code 1 (register write) commits `cmd_data` into register `cmd_reg` of potentiometer `cmd_pot`. The other registers are unchanged.
- R3: Command code 2 (single copy) commits the wiper value of potentiometer `cmd_pot`, taken from `wcr_flat` slice `[p*DATA_W +: DATA_W]` in the cycle of the command pulse, into register `cmd_reg` of that potentiometer. Later changes of `wcr_flat` have no effect.
- R4: Command code 3 (global copy) commits every potentiometer's wiper value, captured at the command pulse, into register `cmd_reg` of that potentiometer.
- R5: A store starts only on the first clock edge that samples `cs_n` high after it was low. A selection that carries no storage command, or only command codes 0 or 4, starts no store and changes no data.
- R6: `wip` rises in the cycle after the edge that detects the `cs_n` release. It stays high for exactly `STORE_CYCLES` cycles. The read port shows the old contents while `wip` is high and the new contents from the cycle in which it falls.
- R7: `status_byte` bit 0 equals `wip` and all other bits are 0. Command code 4 (status read) has no effect on the stored data.
- R8: If `wp_n` is low when the `cs_n` release is detected, the armed store is discarded: `wip` stays 0 and no data changes.
- R9: Storage commands whose pulse arrives while `wip` is high are ignored, and no store follows that selection.
- R10: `standby_ok` is 1 exactly when `cs_n` is high and `wip` is 0.
- R11: When several storage commands arrive within one selection, only the last one is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| wp_n | input | 1 | Write protect, low blocks nonvolatile stores |
| cmd_valid | input | 1 | One-cycle pulse: a complete instruction was received |
| cmd_op | input | 3 | Command code: 0 none, 1 register write, 2 single copy, 3 global copy, 4 status read |
| cmd_pot | input | $clog2(NUM_POTS) | Potentiometer selector |
| cmd_reg | input | $clog2(NUM_REGS) | Data register selector |
| cmd_data | input | DATA_W | Data byte of a register write |
| wcr_flat | input | NUM_POTS*DATA_W | Current wiper values of all potentiometers |
| rd_pot | input | $clog2(NUM_POTS) | Read port potentiometer selector |
| rd_reg | input | $clog2(NUM_REGS) | Read port register selector |
| rd_data | output | DATA_W | Stored value at the read address |
| wip | output | 1 | Write in progress |
| status_byte | output | DATA_W | Status byte, progress flag in bit 0 |
| standby_ok | output | 1 | Deselected and no store running |

## Verification
The assertions check the following on every cycle: the length of each busy window, that a store never begins without a detected `cs_n` release, that a protected release never starts a store, that stored data holds still during a busy window, and the standby rule. Only the bench's scenarios can show which value lands at which address. This covers the capture of wiper values at the command pulse rather than at commit time, the last-command-wins rule, and the dropping of commands during a busy window, because each needs an expected array content that depends on the stimulus history.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_WRITE_REG = 3'd1,
        OP_COPY_ONE  = 3'd2,
        OP_COPY_ALL  = 3'd3,
        OP_STATUS    = 3'd4
    } nv_op_e;

    function automatic logic is_store_op(input logic [2:0] op);
        return (op == OP_WRITE_REG) || (op == OP_COPY_ONE) || (op == OP_COPY_ALL);
    endfunction

endpackage

// File: rtl/nvs_capture.sv
module nvs_capture
    import nvs_pkg::*;
#(
    parameter int NUM_POTS = 4,
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int POT_W    = 2,
    parameter int REG_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_op,
    input  logic [POT_W-1:0]           cmd_pot,
    input  logic [REG_W-1:0]           cmd_reg,
    input  logic [DATA_W-1:0]          cmd_data,
    input  logic [NUM_POTS*DATA_W-1:0] wcr_flat,
    input  logic                       selected,
    input  logic                       busy,
    input  logic                       frame_end,
    output logic                       pending,
    output logic [NUM_POTS-1:0]        pot_mask,
    output logic [REG_W-1:0]           tgt_reg,
    output logic [NUM_POTS*DATA_W-1:0] data_flat
);

    typedef struct packed {
        logic                       pending;
        logic [NUM_POTS-1:0]        mask;
        logic [REG_W-1:0]           reg_idx;
        logic [NUM_POTS*DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;
    logic accept;
    logic [NUM_POTS*DATA_W-1:0] spread_data;

    // Replicate the written byte into every slice; the mask picks the target.
    for (genvar p = 0; p < NUM_POTS; p++) begin : g_spread
        assign spread_data[p*DATA_W +: DATA_W] = cmd_data;
    end

    assign accept = cmd_valid && selected && !busy && is_store_op(cmd_op);

    always_comb begin
        cap_d = cap_q;
        if (frame_end) begin
            cap_d.pending = 1'b0;
        end
        if (accept) begin
            cap_d.pending = 1'b1;
            cap_d.reg_idx = cmd_reg;
            case (cmd_op)
                OP_WRITE_REG: begin
                    cap_d.mask = NUM_POTS'(1) << cmd_pot;
                    cap_d.data = spread_data;
                end
                OP_COPY_ONE: begin
                    cap_d.mask = NUM_POTS'(1) << cmd_pot;
                    cap_d.data = wcr_flat;
                end
                default: begin
                    cap_d.mask = '1;
                    cap_d.data = wcr_flat;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign pending   = cap_q.pending;
    assign pot_mask  = cap_q.mask;
    assign tgt_reg   = cap_q.reg_idx;
    assign data_flat = cap_q.data;

endmodule

// File: rtl/nvs_timer.sv
module nvs_timer #(
    parameter int STORE_CYCLES = 500000,
    parameter int CNT_W        = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] left;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign done = tmr_q.busy && (tmr_q.left == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.left == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.left = tmr_q.left - CNT_W'(1);
            end
        end
        if (start && !tmr_q.busy) begin
            tmr_d.busy = 1'b1;
            tmr_d.left = CNT_W'(STORE_CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = tmr_q.busy;

endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
    parameter int NUM_POTS = 4,
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int POT_W    = 2,
    parameter int REG_W    = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [NUM_POTS-1:0]        pot_mask,
    input  logic [REG_W-1:0]           tgt_reg,
    input  logic [NUM_POTS*DATA_W-1:0] data_flat,
    input  logic [POT_W-1:0]           rd_pot,
    input  logic [REG_W-1:0]           rd_reg,
    output logic [DATA_W-1:0]          rd_data
);

    typedef logic [NUM_POTS-1:0][NUM_REGS-1:0][DATA_W-1:0] mem_t;

    mem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (commit) begin
            for (int p = 0; p < NUM_POTS; p++) begin
                if (pot_mask[p]) begin
                    mem_d[p][tgt_reg] = data_flat[p*DATA_W +: DATA_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_pot][rd_reg];

endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq #(
    parameter int NUM_POTS     = 4,
    parameter int NUM_REGS     = 4,
    parameter int DATA_W       = 8,
    parameter int STORE_CYCLES = 500000
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          wp_n,
    input  logic                          cmd_valid,
    input  logic [2:0]                    cmd_op,
    input  logic [$clog2(NUM_POTS)-1:0]   cmd_pot,
    input  logic [$clog2(NUM_REGS)-1:0]   cmd_reg,
    input  logic [DATA_W-1:0]             cmd_data,
    input  logic [NUM_POTS*DATA_W-1:0]    wcr_flat,
    input  logic [$clog2(NUM_POTS)-1:0]   rd_pot,
    input  logic [$clog2(NUM_REGS)-1:0]   rd_reg,
    output logic [DATA_W-1:0]             rd_data,
    output logic                          wip,
    output logic [DATA_W-1:0]             status_byte,
    output logic                          standby_ok
);

    localparam int POT_W = $clog2(NUM_POTS);
    localparam int REG_W = $clog2(NUM_REGS);
    localparam int CNT_W = $clog2(STORE_CYCLES + 1);

    typedef struct packed {
        logic cs_n;
    } top_t;

    top_t top_d, top_q;

    logic                       frame_end;
    logic                       start;
    logic                       pending;
    logic                       done;
    logic [NUM_POTS-1:0]        pot_mask;
    logic [REG_W-1:0]           tgt_reg;
    logic [NUM_POTS*DATA_W-1:0] data_flat;

    // Release of chip select: high now, low at the previous edge.
    assign frame_end = cs_n && !top_q.cs_n;
    assign start     = frame_end && pending && wp_n;

    always_comb begin
        top_d      = top_q;
        top_d.cs_n = cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '{cs_n: 1'b1};
        end else begin
            top_q <= top_d;
        end
    end

    nvs_capture #(
        .NUM_POTS(NUM_POTS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
        .POT_W(POT_W), .REG_W(REG_W)
    ) u_capture (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pot(cmd_pot),
        .cmd_reg(cmd_reg), .cmd_data(cmd_data), .wcr_flat(wcr_flat),
        .selected(!cs_n), .busy(wip), .frame_end(frame_end),
        .pending(pending), .pot_mask(pot_mask), .tgt_reg(tgt_reg),
        .data_flat(data_flat)
    );

    nvs_timer #(
        .STORE_CYCLES(STORE_CYCLES), .CNT_W(CNT_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(wip), .done(done)
    );

    nvs_array #(
        .NUM_POTS(NUM_POTS), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
        .POT_W(POT_W), .REG_W(REG_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .commit(done), .pot_mask(pot_mask),
        .tgt_reg(tgt_reg), .data_flat(data_flat),
        .rd_pot(rd_pot), .rd_reg(rd_reg), .rd_data(rd_data)
    );

    assign status_byte = {{(DATA_W-1){1'b0}}, wip};
    assign standby_ok  = cs_n && !wip;

endmodule

// File: rtl/nvs_check.sv
module nvs_check #(
    parameter int STORE_CYCLES = 500000,
    parameter int POT_W        = 2,
    parameter int REG_W        = 2,
    parameter int DATA_W       = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wp_n,
    input logic              wip,
    input logic              standby_ok,
    input logic [POT_W-1:0]  rd_pot,
    input logic [REG_W-1:0]  rd_reg,
    input logic [DATA_W-1:0] rd_data
);

    localparam int RUN_W = $clog2(STORE_CYCLES + 1) + 1;

    logic [RUN_W-1:0] run_q;
    logic             prev_cs_q;
    logic             prev_wip_q;
    logic             release_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            prev_cs_q  <= 1'b1;
            prev_wip_q <= 1'b0;
        end else begin
            run_q      <= wip ? run_q + RUN_W'(1) : '0;
            prev_cs_q  <= cs_n;
            prev_wip_q <= wip;
        end
    end

    assign release_seen = cs_n && !prev_cs_q;

    // R6: busy window never exceeds its length
    p_wip_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> (run_q < RUN_W'(STORE_CYCLES)));

    // R6: a busy window that ends has run its full length
    p_wip_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wip && run_q != '0) |-> (run_q == RUN_W'(STORE_CYCLES)));

    // R5: no store begins without a detected release of chip select
    p_start_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wip && !release_seen) |=> !wip);

    // R8: a protected release never starts a store
    p_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (release_seen && !wp_n && !wip) |=> !wip);

    // R6: stored data holds while the busy window runs
    p_stable_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wip && prev_wip_q && $stable(rd_pot) && $stable(rd_reg)) |-> $stable(rd_data));

    // R10: no standby while selected or busy
    p_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n || wip) |-> !standby_ok);

endmodule

bind nv_store_seq nvs_check #(
    .STORE_CYCLES(STORE_CYCLES), .POT_W(POT_W), .REG_W(REG_W), .DATA_W(DATA_W)
) u_nvs_check (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .wip(wip),
    .standby_ok(standby_ok), .rd_pot(rd_pot), .rd_reg(rd_reg), .rd_data(rd_data)
);

// File: tb/nv_store_seq_test.sv
module nv_store_seq_test;

    localparam int NP = 4;
    localparam int NR = 4;
    localparam int DW = 8;
    localparam int SC = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          wp_n = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [1:0]    cmd_pot = '0;
    logic [1:0]    cmd_reg = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [NP*DW-1:0] wcr_flat;
    logic [1:0]    rd_pot = '0;
    logic [1:0]    rd_reg = '0;
    logic [DW-1:0] rd_data;
    logic          wip;
    logic [DW-1:0] status_byte;
    logic          standby_ok;

    logic [DW-1:0] wcr_v [NP];
    logic [DW-1:0] ref_mem [NP][NR];
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) wcr_flat[p*DW +: DW] = wcr_v[p];
    end

    nv_store_seq #(.NUM_POTS(NP), .NUM_REGS(NR), .DATA_W(DW), .STORE_CYCLES(SC)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
        .wcr_flat(wcr_flat), .rd_pot(rd_pot), .rd_reg(rd_reg), .rd_data(rd_data),
        .wip(wip), .status_byte(status_byte), .standby_ok(standby_ok)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic mem_check(input string req);
        for (int p = 0; p < NP; p++) begin
            for (int r = 0; r < NR; r++) begin
                rd_pot = 2'(p);
                rd_reg = 2'(r);
                #1;
                check(req, int'(rd_data), int'(ref_mem[p][r]));
            end
        end
    endtask

    task automatic issue(input logic [2:0] op, input int pot, input int rg, input logic [DW-1:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pot = 2'(pot); cmd_reg = 2'(rg); cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    // One selection carrying one command; counts the busy window after release.
    task automatic frame(input logic [2:0] op, input int pot, input int rg,
                         input logic [DW-1:0] data, input logic wp,
                         input int exp_highs, input string req);
        int highs;
        @(negedge clk);
        cs_n = 1'b0; wp_n = wp;
        issue(op, pot, rg, data);
        for (int p = 0; p < NP; p++) wcr_v[p] = wcr_v[p] ^ 8'hFF; // after capture
        @(negedge clk);
        cs_n = 1'b1;
        highs = 0;
        for (int k = 0; k < SC + 4; k++) begin
            @(negedge clk);
            if (wip) highs++;
            if (k == 2) begin
                check({req, " R7 status"}, int'(status_byte), exp_highs != 0 ? 1 : 0);
                check({req, " R10 standby"}, int'(standby_ok), exp_highs != 0 ? 0 : 1);
                rd_pot = 2'(pot); rd_reg = 2'(rg); #1;
                check({req, " R6 old data while busy"}, int'(rd_data), int'(ref_mem[pot][rg]));
            end
        end
        check({req, " R6 busy length"}, highs, exp_highs);
        wp_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [DW-1:0] cap [NP];
        for (int p = 0; p < NP; p++) begin
            wcr_v[p] = 8'(p * 29 + 3);
            for (int r = 0; r < NR; r++) ref_mem[p][r] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 wip", int'(wip), 0);
        check("R1 status", int'(status_byte), 0);
        check("R10 idle standby", int'(standby_ok), 1);
        mem_check("R1 reset data");

        // R2: register write sweep over every address
        for (int p = 0; p < NP; p++) begin
            for (int r = 0; r < NR; r++) begin
                logic [DW-1:0] v;
                v = 8'(p * 37 + r * 11 + 5);
                frame(3'd1, p, r, v, 1'b1, SC, "R2 write");
                ref_mem[p][r] = v;
            end
        end
        mem_check("R2 write sweep");

        // R3: single copy, wiper value captured at the command pulse
        for (int p = 0; p < NP; p++) begin
            int r;
            r = (p + 1) % NR;
            cap[p] = wcr_v[p];
            frame(3'd2, p, r, 8'h00, 1'b1, SC, "R3 copy one");
            ref_mem[p][r] = cap[p];
            mem_check("R3 copy one");
        end

        // R4: global copy for each register slot
        for (int r = 0; r < NR; r++) begin
            for (int p = 0; p < NP; p++) cap[p] = wcr_v[p];
            frame(3'd3, 0, r, 8'h00, 1'b1, SC, "R4 copy all");
            for (int p = 0; p < NP; p++) ref_mem[p][r] = cap[p];
            mem_check("R4 copy all");
        end

        // R8: protected release discards the store
        frame(3'd1, 1, 2, 8'hC3, 1'b0, 0, "R8 protect write");
        frame(3'd3, 0, 1, 8'h00, 1'b0, 0, "R8 protect copy all");
        mem_check("R8 no change");

        // R7 / R5: status read and empty command carry no store
        frame(3'd4, 2, 2, 8'h99, 1'b1, 0, "R7 status op");
        frame(3'd0, 3, 0, 8'h77, 1'b1, 0, "R5 no store op");
        mem_check("R5 R7 no change");

        // R5: selection with no command pulse at all
        begin
            int highs;
            @(negedge clk); cs_n = 1'b0;
            repeat (4) @(negedge clk);
            cs_n = 1'b1;
            highs = 0;
            repeat (SC + 4) begin @(negedge clk); if (wip) highs++; end
            check("R5 empty selection", highs, 0);
            mem_check("R5 empty selection data");
        end

        // R11: last storage command within one selection wins
        begin
            int highs;
            @(negedge clk); cs_n = 1'b0;
            issue(3'd1, 0, 1, 8'hAA);
            issue(3'd1, 2, 3, 8'h55);
            @(negedge clk); cs_n = 1'b1;
            highs = 0;
            repeat (SC + 4) begin @(negedge clk); if (wip) highs++; end
            check("R11 busy length", highs, SC);
            ref_mem[2][3] = 8'h55;
            mem_check("R11 last wins");
        end

        // R9: storage command during busy window is ignored
        begin
            @(negedge clk); cs_n = 1'b0;
            issue(3'd1, 3, 3, 8'h11);
            @(negedge clk); cs_n = 1'b1;
            repeat (2) @(negedge clk);
            check("R9 busy before", int'(wip), 1);
            check("R9 R7 status busy", int'(status_byte), 1);
            cs_n = 1'b0;
            check("R10 selected", int'(standby_ok), 0);
            issue(3'd1, 1, 0, 8'hEE);
            @(negedge clk); cs_n = 1'b1;
            while (wip) @(negedge clk);
            ref_mem[3][3] = 8'h11;
            repeat (SC + 4) @(negedge clk);
            check("R9 no second store", int'(wip), 0);
            mem_check("R9 ignored data");
        end

        summary();
        $finish;
    end

endmodule